// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block gathers a set of peripheral interrupt request lines and merges them onto one processor interrupt output. A separate non-maskable request goes to an output of its own. Every incoming line, the non-maskable one included, passes through a two-flop synchronizer before any logic looks at it. Each maskable line can be set to level or edge triggering, and to either polarity. Edge events are held in pending latches until the processor acknowledges them.

A small register port lets software set the per-line enable, trigger type and polarity bits. The same port reads back the live request status and clears edge latches by writing ones. The controller always presents the index of the lowest-numbered unmasked line that is requesting, together with a valid flag, so the processor can dispatch without polling.

Top module: `irq_combiner`

## Requirements
- R1: A request line is used only after a two-flop synchronizer. A level-mode line that changes before rising edge 1 changes `irq_o` at rising edge 3 and not before. An edge-mode capture raises `irq_o` at rising edge 4 and not before.
- R2: Enable bits are active-high (1 = enabled). A line whose enable bit is 0 never raises `irq_o` and never wins the index. Its request still shows in the status readback.
- R3: `nmi_o` follows `nmi_i` three rising edges later, whatever the enable bits hold.
- R4: In level mode (mode bit 0), a line requests while it sits at its active level (polarity bit 0 = high, 1 = low). It stops requesting once released.
- R5: In edge mode (mode bit 1), polarity bit 0 selects the rising transition and 1 selects the falling one. The captured event stays pending after the line returns to idle.
- R6: Writing to select 3 clears every pending latch whose data bit is 1. Latches whose data bit is 0 are left unchanged.
- R7: When a qualifying edge and an acknowledge of the same line meet in one cycle, the latch stays set.
- R8: Among unmasked requests the lowest index wins. `win_idx_o` carries that index and `win_valid_o` is 1. With no request, `win_valid_o` is 0 and `win_idx_o` is 0.
- R9: `irq_o` is 1 exactly when at least one enabled line is requesting, one edge after the request and enable are both present.
- R10: Register selects are 0 = enable, 1 = mode, 2 = polarity, 3 = status read / acknowledge write. Reads are combinational from `cfg_rsel_i`, and status shows every line's request before enabling.
- R11: After reset all enable, mode and polarity bits are 0, no latch is pending, and `irq_o`, `nmi_o`, `win_valid_o` and `win_idx_o` are 0.
- R12: A line in level mode holds no pending latch, so a change of polarity or a switch to level mode never leaves a stale edge behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC | Maskable request lines, asynchronous |
| nmi_i | input | 1 | Non-maskable request line, asynchronous |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select for writes |
| cfg_wdata_i | input | NUM_SRC | Write data, one bit per line |
| cfg_rsel_i | input | 2 | Register select for reads |
| cfg_rdata_o | output | NUM_SRC | Read data for the selected register |
| irq_o | output | 1 | Combined maskable interrupt to the processor |
| nmi_o | output | 1 | Synchronized non-maskable interrupt |
| win_idx_o | output | IDX_W | Index of the winning line |
| win_valid_o | output | 1 | Index is meaningful |

## Verification
A level-mode request and the non-maskable line reach their outputs on the third rising edge after the input moves. An edge capture reaches `irq_o` on the fourth edge. A register write, or a change of enable, shows on `irq_o` one edge after the write edge. The bench drives inputs on falling edges. For latency it samples on the falling edge just before and just after the due edge. In every other case it waits five cycles so that all pipelines have settled. The acknowledge collision is staged by starting the write on the falling edge after the second synchronizer stage captures the transition, so the clear and the capture share one edge.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_ENABLE = 2'd0,
        SEL_MODE   = 2'd1,
        SEL_POL    = 2'd2,
        SEL_STATUS = 2'd3
    } cfg_sel_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;

endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] mode_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] edge_hit_o,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] req_o
);

    typedef struct packed {
        logic [N-1:0] dly;
        logic [N-1:0] pend;
    } det_t;

    det_t st_d, st_q;
    logic [N-1:0] hit;
    logic [N-1:0] lvl;

    for (genvar g = 0; g < N; g++) begin : g_line
        logic rise, fall;
        assign rise     = line_i[g] & ~st_q.dly[g];
        assign fall     = ~line_i[g] & st_q.dly[g];
        assign hit[g]   = mode_i[g] & (pol_i[g] ? fall : rise);
        assign lvl[g]   = line_i[g] ^ pol_i[g];
        assign req_o[g] = mode_i[g] ? st_q.pend[g] : lvl[g];
    end

    always_comb begin
        st_d      = st_q;
        st_d.dly  = line_i;
        st_d.pend = mode_i & (hit | (st_q.pend & ~ack_i));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign edge_hit_o = hit;
    assign pend_o     = st_q.pend;

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
        any_o = |vec_i;
    end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [SEL_W-1:0] wsel_i,
    input  logic [N-1:0]     wdata_i,
    input  logic [SEL_W-1:0] rsel_i,
    input  logic [N-1:0]     status_i,
    output logic [N-1:0]     rdata_o,
    output logic [N-1:0]     enable_o,
    output logic [N-1:0]     mode_o,
    output logic [N-1:0]     pol_o,
    output logic [N-1:0]     ack_o
);

    typedef struct packed {
        logic [N-1:0] enable;
        logic [N-1:0] mode;
        logic [N-1:0] pol;
    } cfg_t;

    cfg_t     st_d, st_q;
    cfg_sel_e wsel, rsel;

    assign wsel = cfg_sel_e'(wsel_i);
    assign rsel = cfg_sel_e'(rsel_i);

    always_comb begin
        st_d  = st_q;
        ack_o = '0;
        if (we_i) begin
            unique case (wsel)
                SEL_ENABLE: st_d.enable = wdata_i;
                SEL_MODE:   st_d.mode   = wdata_i;
                SEL_POL:    st_d.pol    = wdata_i;
                SEL_STATUS: ack_o       = wdata_i;
                default:    ack_o       = '0;
            endcase
        end
    end

    always_comb begin
        unique case (rsel)
            SEL_ENABLE: rdata_o = st_q.enable;
            SEL_MODE:   rdata_o = st_q.mode;
            SEL_POL:    rdata_o = st_q.pol;
            SEL_STATUS: rdata_o = status_i;
            default:    rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable_o = st_q.enable;
    assign mode_o   = st_q.mode;
    assign pol_o    = st_q.pol;

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = irq_pkg::idx_width(NUM_SRC)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               nmi_i,
    input  logic               cfg_we_i,
    input  logic [1:0]         cfg_sel_i,
    input  logic [NUM_SRC-1:0] cfg_wdata_i,
    input  logic [1:0]         cfg_rsel_i,
    output logic [NUM_SRC-1:0] cfg_rdata_o,
    output logic               irq_o,
    output logic               nmi_o,
    output logic [IDX_W-1:0]   win_idx_o,
    output logic               win_valid_o
);

    typedef struct packed {
        logic             irq;
        logic             nmi;
        logic [IDX_W-1:0] idx;
        logic             valid;
    } out_t;

    logic [NUM_SRC-1:0] line_s;
    logic               nmi_s;
    logic [NUM_SRC-1:0] enable_q, mode_q, pol_q, ack_vec;
    logic [NUM_SRC-1:0] edge_hit, pend_q, req_vec, masked;
    logic [IDX_W-1:0]   win_idx;
    logic               win_any;
    out_t               out_d, out_q;

    irq_sync #(.W(NUM_SRC)) u_line_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (req_i),
        .sync_o  (line_s)
    );

    irq_sync #(.W(1)) u_nmi_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (nmi_i),
        .sync_o  (nmi_s)
    );

    irq_regs #(.N(NUM_SRC)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (cfg_we_i),
        .wsel_i   (cfg_sel_i),
        .wdata_i  (cfg_wdata_i),
        .rsel_i   (cfg_rsel_i),
        .status_i (req_vec),
        .rdata_o  (cfg_rdata_o),
        .enable_o (enable_q),
        .mode_o   (mode_q),
        .pol_o    (pol_q),
        .ack_o    (ack_vec)
    );

    irq_detect #(.N(NUM_SRC)) u_detect (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .line_i     (line_s),
        .mode_i     (mode_q),
        .pol_i      (pol_q),
        .ack_i      (ack_vec),
        .edge_hit_o (edge_hit),
        .pend_o     (pend_q),
        .req_o      (req_vec)
    );

    assign masked = req_vec & enable_q;

    irq_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .vec_i (masked),
        .idx_o (win_idx),
        .any_o (win_any)
    );

    always_comb begin
        out_d       = out_q;
        out_d.irq   = win_any;
        out_d.valid = win_any;
        out_d.idx   = win_idx;
        out_d.nmi   = nmi_s;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_o       = out_q.irq;
    assign nmi_o       = out_q.nmi;
    assign win_idx_o   = out_q.idx;
    assign win_valid_o = out_q.valid;

endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             nmi_i,
    input logic             nmi_o,
    input logic             irq_o,
    input logic [IDX_W-1:0] win_idx_o,
    input logic             win_valid_o,
    input logic [N-1:0]     enable_q,
    input logic [N-1:0]     mode_q,
    input logic [N-1:0]     pend_q,
    input logic [N-1:0]     edge_hit,
    input logic [N-1:0]     ack_vec,
    input logic [N-1:0]     req_vec
);

    logic [2:0]   nmi_hist;
    logic [1:0]   since_rst;
    logic [N-1:0] prev_en, prev_req, prev_keep, prev_hit, prev_clr;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            nmi_hist  <= '0;
            since_rst <= '0;
            prev_en   <= '0;
            prev_req  <= '0;
            prev_keep <= '0;
            prev_hit  <= '0;
            prev_clr  <= '0;
        end else begin
            nmi_hist  <= {nmi_hist[1:0], nmi_i};
            if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
            prev_en   <= enable_q;
            prev_req  <= req_vec;
            prev_keep <= pend_q & mode_q & ~ack_vec;
            prev_hit  <= edge_hit;
            prev_clr  <= ack_vec & ~edge_hit;
        end
    end

    function automatic logic [N-1:0] below(input logic [IDX_W-1:0] idx);
        logic [N-1:0] m;
        m = '0;
        for (int i = 0; i < N; i++) begin
            if (i < int'(idx)) m[i] = 1'b1;
        end
        return m;
    endfunction

    AST_NMI_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst == 2'd3) |-> (nmi_o == nmi_hist[2])); // R3

    AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prev_en == '0) |-> !irq_o); // R2

    AST_WIN_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_valid_o |-> (prev_en[win_idx_o] && prev_req[win_idx_o])); // R2

    AST_PRIO_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_valid_o |-> ((prev_req & prev_en & below(win_idx_o)) == '0)); // R8

    AST_IDLE_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !win_valid_o |-> (win_idx_o == '0)); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pend_q & prev_clr) == '0)); // R6

    AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((~pend_q & prev_keep) == '0)); // R5

    AST_EDGE_BEATS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((~pend_q & prev_hit) == '0)); // R7

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pend_q & ~mode_q) == '0) || ($past(mode_q) != mode_q)); // R12

endmodule

bind irq_combiner irq_combiner_chk #(.N(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nmi_i       (nmi_i),
    .nmi_o       (nmi_o),
    .irq_o       (irq_o),
    .win_idx_o   (win_idx_o),
    .win_valid_o (win_valid_o),
    .enable_q    (enable_q),
    .mode_q      (mode_q),
    .pend_q      (pend_q),
    .edge_hit    (edge_hit),
    .ack_vec     (ack_vec),
    .req_vec     (req_vec)
);

// File: tb/irq_combiner_tb_top.sv
module irq_combiner_tb_top;

    localparam int N     = 8;
    localparam int IDX_W = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         nmi = 1'b0;
    logic         we = 1'b0;
    logic [1:0]   wsel = '0;
    logic [N-1:0] wdata = '0;
    logic [1:0]   rsel = '0;
    logic [N-1:0] rdata;
    logic         irq, nmi_out, valid;
    logic [IDX_W-1:0] idx;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_combiner #(.NUM_SRC(N)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_i       (req),
        .nmi_i       (nmi),
        .cfg_we_i    (we),
        .cfg_sel_i   (wsel),
        .cfg_wdata_i (wdata),
        .cfg_rsel_i  (rsel),
        .cfg_rdata_o (rdata),
        .irq_o       (irq),
        .nmi_o       (nmi_out),
        .win_idx_o   (idx),
        .win_valid_o (valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [N-1:0] d);
        we = 1'b1; wsel = s; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [N-1:0] d);
        rsel = s;
        #1;
        d = rdata;
    endtask

    function automatic logic [N-1:0] exp_req(input logic [N-1:0] base, input logic [N-1:0] nw,
                                             input logic [N-1:0] md, input logic [N-1:0] pl);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            if (md[i]) r[i] = pl[i] ? (base[i] & ~nw[i]) : (~base[i] & nw[i]);
            else       r[i] = nw[i] ^ pl[i];
        end
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] lowest(input logic [N-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = N - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
        return r;
    endfunction

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [N-1:0] d;
        void'($urandom(32'd4242));
        waitn(3);
        rst_n = 1'b1;
        waitn(1);
        // R11 reset state
        rd(2'd0, d); chk("R11 enable", d, 0);
        rd(2'd1, d); chk("R11 mode", d, 0);
        rd(2'd2, d); chk("R11 pol", d, 0);
        rd(2'd3, d); chk("R11 status", d, 0);
        chk("R11 outputs", {irq, nmi_out, valid, idx}, 0);

        // R2 all lines masked: status shows, irq silent
        req = 8'hFF; waitn(5);
        chk("R2 masked irq", irq, 0);
        rd(2'd3, d); chk("R2 R10 status visible", d, 8'hFF);
        req = '0; waitn(5);

        // R3 nmi latency, mask all zero
        nmi = 1'b1; waitn(2);
        chk("R3 nmi early", nmi_out, 0);
        waitn(1);
        chk("R3 nmi due", nmi_out, 1);
        nmi = 1'b0; waitn(3);
        chk("R3 nmi off", nmi_out, 0);

        // R1 R4 level latency and release
        wr(2'd0, 8'h10);
        rd(2'd0, d); chk("R10 enable readback", d, 8'h10);
        req[4] = 1'b1; waitn(2);
        chk("R1 level early", irq, 0);
        waitn(1);
        chk("R1 R9 level due", {irq, valid, idx}, {1'b1, 1'b1, 3'd4});
        req[4] = 1'b0; waitn(3);
        chk("R4 level release", {irq, valid}, 0);

        // R8 priority
        wr(2'd0, 8'hFF);
        req = 8'b0010_1010; waitn(5);
        chk("R8 lowest wins", {valid, idx}, {1'b1, 3'd1});
        wr(2'd0, 8'hFD); waitn(1);
        chk("R8 R2 next after mask", {valid, idx}, {1'b1, 3'd3});
        req = '0; waitn(5);
        chk("R8 idle idx", {valid, idx}, 0);

        // R5 rising edge line 2
        wr(2'd1, 8'h04); wr(2'd0, 8'h04);
        rd(2'd1, d); chk("R10 mode readback", d, 8'h04);
        req[2] = 1'b1; waitn(3);
        chk("R1 edge early", irq, 0);
        waitn(1);
        chk("R1 R5 edge due", {irq, idx}, {1'b1, 3'd2});
        req[2] = 1'b0; waitn(5);
        chk("R5 latch holds", irq, 1);
        rd(2'd3, d); chk("R5 status held", d, 8'h04);
        wr(2'd3, 8'hFB);
        rd(2'd3, d); chk("R6 zero bits no clear", d, 8'h04);
        wr(2'd3, 8'h04);
        rd(2'd3, d); chk("R6 ack clears", d, 8'h00);
        waitn(1);
        chk("R6 irq drops", irq, 0);

        // R5 falling edge line 6
        req[6] = 1'b1; waitn(5);
        wr(2'd1, 8'h44); wr(2'd2, 8'h40); wr(2'd0, 8'h40);
        waitn(3);
        chk("R5 no edge on config", irq, 0);
        req[6] = 1'b0; waitn(5);
        chk("R5 falling captured", {irq, idx}, {1'b1, 3'd6});
        wr(2'd3, 8'h40);
        req[6] = 1'b1; waitn(5);
        chk("R5 rising ignored when falling", irq, 0);

        // R7 edge meets ack in same cycle, line 2 rising
        wr(2'd0, 8'h04);
        req[2] = 1'b1; waitn(5); req[2] = 1'b0; waitn(5);
        rd(2'd3, d); chk("R7 preset", d[2], 1);
        req[2] = 1'b1;
        waitn(2);
        wr(2'd3, 8'h04);
        rd(2'd3, d); chk("R7 edge wins over ack", d[2], 1);
        wr(2'd3, 8'h04);
        rd(2'd3, d); chk("R7 later ack clears", d[2], 0);
        req = '0; waitn(5);

        // R4 active-low level on line 0, R12 no latch in level mode
        wr(2'd1, 8'h00); wr(2'd2, 8'h01); wr(2'd0, 8'h01);
        req[0] = 1'b1; waitn(5);
        chk("R4 low level idle", irq, 0);
        req[0] = 1'b0; waitn(5);
        chk("R4 low level active", {irq, idx}, {1'b1, 3'd0});
        req[0] = 1'b1; waitn(5);
        rd(2'd3, d); chk("R12 level leaves nothing", d, 8'h00);
        rd(2'd2, d); chk("R10 pol readback", d, 8'h01);

        // random patterns R1 R4 R5 R8 R9
        for (int it = 0; it < 60; it++) begin
            logic [N-1:0] m, md, pl, base, nw, er;
            m = N'($urandom); md = N'($urandom); pl = N'($urandom);
            base = N'($urandom); nw = N'($urandom);
            wr(2'd0, m); wr(2'd1, md); wr(2'd2, pl);
            req = base; waitn(5);
            wr(2'd3, '1); waitn(1);
            req = nw; waitn(5);
            er = exp_req(base, nw, md, pl);
            rd(2'd3, d); chk("R4 R5 random status", d, er);
            chk("R9 random irq", irq, |(er & m));
            chk("R8 random index", {valid, idx}, {|(er & m), lowest(er & m)});
        end

        summary();
    end

endmodule